// File: doc/BRIEF.md
# Dual-Clock FIFO with Reserve Margins

This block carries data words from a write clock domain to an unrelated read clock domain. Each side has its own clock and its own active-low asynchronous reset. Each side keeps a binary pointer one bit wider than the storage address. The extra bit lets a pointer difference tell a full queue from an empty one. The pointer is re-encoded in Gray code before it crosses to the other side, so each step changes only one bit. The crossing uses a flip-flop chain whose length is a parameter, with a minimum of 2.

Both status flags are pulled inward by a `RESERVE` margin. `full_o` rises while RESERVE or fewer slots are still free. `empty_o` stays high while RESERVE or fewer words are held. Each side computes its flag from its own pointer and the synchronized copy of the other side's pointer. That copy can only be stale in the safe direction, so a flag may stay asserted longer than needed but never drops too early.

Each side's pointer registers are enabled only by an accepted transfer. Its flag register is enabled only by a local request or by a change in the synchronized remote pointer. With no traffic, the whole side holds still.

Top module: `rsv_async_fifo`

## Requirements
- R1: A write is taken only at a write-clock edge where `wr_en_i` is 1 and `full_o` is 0. The write Gray pointer changes in exactly one bit per taken write and holds otherwise. Writes made while `full_o` is 1 are dropped.
- R2: A read is taken only at a read-clock edge where `rd_en_i` is 1 and `empty_o` is 0. The read Gray pointer changes in exactly one bit per taken read and holds otherwise. Reads made while `empty_o` is 1 have no effect.
- R3: Words leave in the order they were taken. `rd_data_o` loads the oldest word at the read edge that takes a read, and holds its value at every other edge.
- R4: `full_o` is never 0 while free space (2^ADDR_W minus occupancy) is at or below RESERVE, and the queue never holds more than 2^ADDR_W words. Writes alone, with no reads, fill the queue to exactly 2^ADDR_W - RESERVE words.
- R5: `empty_o` is never 0 while occupancy is at or below RESERVE. Reads alone, with no writes, drain the queue down to min(occupancy, RESERVE) words.
- R6: While a side is in reset, and after its reset is released, `empty_o` is 1, `full_o` is 0 and `rd_data_o` is 0.
- R7: After both sides stop transferring, each flag matches the true occupancy within SYNC_STAGES+3 edges of its own clock. That is, `full_o` = (free <= RESERVE) and `empty_o` = (occupancy <= RESERVE).
- R8: While both sides are idle, `full_o`, `empty_o` and `rd_data_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| wrst_ni | input | 1 | Write-side asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Word to store |
| full_o | output | 1 | No room beyond the reserve margin; writes are dropped |
| rclk_i | input | 1 | Read-side clock |
| rrst_ni | input | 1 | Read-side asynchronous reset, active low |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Word from the last taken read, registered |
| empty_o | output | 1 | Occupancy at or below the reserve margin; reads have no effect |

## Verification
The bench builds the block with ADDR_W=3 (eight entries), RESERVE=1, SYNC_STAGES=3 and 8-bit data. With these values, both reserve boundaries and pointer wrap are reached within a few dozen transfers. It also uses a crossing longer than the minimum, so flag lag is clearly visible. The write clock runs at 10 ns and the read clock at 14 ns. The bench sweeps every pairing of write and read request spacing from 0 (idle) to 3 cycles, including back-to-back transfers on both sides at the boundaries. After each pairing, it checks data order and the settled flags against occupancy counted from its own tallies of taken transfers.

// File: rtl/rsv_fifo_pkg.sv
package rsv_fifo_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/rsv_fifo_sync.sv
module rsv_fifo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsv_fifo_wr_ctl.sv
module rsv_fifo_wr_ctl
  import rsv_fifo_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int RESERVE = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [ADDR_W:0] rgray_s_i,
  output logic            full_o,
  output logic            take_o,
  output logic [ADDR_W:0] bin_o,
  output logic [ADDR_W:0] gray_o
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] bin_q, gray_q, seen_q, bin_nxt, rbin_s, free_nxt;
  logic          full_q, flag_ce;

  assign take_o   = req_i & ~full_q;
  assign bin_nxt  = bin_q + PW'(take_o);
  assign rbin_s   = PW'(gray2bin(32'(rgray_s_i)));
  assign free_nxt = PW'(DEPTH) - (bin_nxt - rbin_s);
  // flag logic wakes only on a local request or a remote pointer move
  assign flag_ce  = req_i | (rgray_s_i != seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
      seen_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (take_o) begin
        bin_q  <= bin_nxt;
        gray_q <= PW'(bin2gray(32'(bin_nxt)));
      end
      if (flag_ce) begin
        seen_q <= rgray_s_i;
        full_q <= (free_nxt <= PW'(RESERVE));
      end
    end
  end

  assign full_o = full_q;
  assign bin_o  = bin_q;
  assign gray_o = gray_q;
endmodule

// File: rtl/rsv_fifo_rd_ctl.sv
module rsv_fifo_rd_ctl
  import rsv_fifo_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int RESERVE = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [ADDR_W:0] wgray_s_i,
  output logic            empty_o,
  output logic            take_o,
  output logic [ADDR_W:0] bin_o,
  output logic [ADDR_W:0] gray_o
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] bin_q, gray_q, seen_q, bin_nxt, wbin_s, occ_nxt;
  logic          empty_q, flag_ce;

  assign take_o  = req_i & ~empty_q;
  assign bin_nxt = bin_q + PW'(take_o);
  assign wbin_s  = PW'(gray2bin(32'(wgray_s_i)));
  assign occ_nxt = wbin_s - bin_nxt;
  assign flag_ce = req_i | (wgray_s_i != seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q   <= '0;
      gray_q  <= '0;
      seen_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      if (take_o) begin
        bin_q  <= bin_nxt;
        gray_q <= PW'(bin2gray(32'(bin_nxt)));
      end
      if (flag_ce) begin
        seen_q  <= wgray_s_i;
        empty_q <= (occ_nxt <= PW'(RESERVE));
      end
    end
  end

  assign empty_o = empty_q;
  assign bin_o   = bin_q;
  assign gray_o  = gray_q;
endmodule

// File: rtl/rsv_fifo_mem.sv
module rsv_fifo_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni)  rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/rsv_async_fifo.sv
module rsv_async_fifo #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int RESERVE     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o
);
  localparam int PW = ADDR_W + 1;
  localparam int SS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [PW-1:0] wbin, wgray, wgray_s, rbin, rgray, rgray_s;
  logic          wtake, rtake;

  rsv_fifo_wr_ctl #(.ADDR_W(ADDR_W), .RESERVE(RESERVE)) u_wr (
    .clk_i(wclk_i), .rst_ni(wrst_ni), .req_i(wr_en_i), .rgray_s_i(rgray_s),
    .full_o(full_o), .take_o(wtake), .bin_o(wbin), .gray_o(wgray)
  );

  rsv_fifo_rd_ctl #(.ADDR_W(ADDR_W), .RESERVE(RESERVE)) u_rd (
    .clk_i(rclk_i), .rst_ni(rrst_ni), .req_i(rd_en_i), .wgray_s_i(wgray_s),
    .empty_o(empty_o), .take_o(rtake), .bin_o(rbin), .gray_o(rgray)
  );

  rsv_fifo_sync #(.W(PW), .STAGES(SS)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rrst_ni), .d_i(wgray), .q_o(wgray_s)
  );

  rsv_fifo_sync #(.W(PW), .STAGES(SS)) u_r2w (
    .clk_i(wclk_i), .rst_ni(wrst_ni), .d_i(rgray), .q_o(rgray_s)
  );

  rsv_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk_i(wclk_i), .we_i(wtake), .waddr_i(wbin[ADDR_W-1:0]), .wdata_i(wr_data_i),
    .rclk_i(rclk_i), .rrst_ni(rrst_ni), .re_i(rtake), .raddr_i(rbin[ADDR_W-1:0]),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/rsv_async_fifo_chk.sv
module rsv_async_fifo_chk #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 4,
  parameter int RESERVE = 2
) (
  input logic              wclk_i,
  input logic              wrst_ni,
  input logic              wr_en_i,
  input logic              full_o,
  input logic [ADDR_W:0]   wbin_i,
  input logic [ADDR_W:0]   wgray_i,
  input logic              rclk_i,
  input logic              rrst_ni,
  input logic              rd_en_i,
  input logic              empty_o,
  input logic [ADDR_W:0]   rbin_i,
  input logic [ADDR_W:0]   rgray_i,
  input logic [DATA_W-1:0] rd_data_o
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  AST_WPTR_HOLD: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    !(wr_en_i && !full_o) |=> $stable(wgray_i)); // R1
  AST_WPTR_STEP: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (wr_en_i && !full_o) |=> ($countones(wgray_i ^ $past(wgray_i)) == 1)); // R1
  AST_RPTR_HOLD: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    !(rd_en_i && !empty_o) |=> $stable(rgray_i)); // R2
  AST_RPTR_STEP: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (rd_en_i && !empty_o) |=> ($countones(rgray_i ^ $past(rgray_i)) == 1)); // R2
  AST_RDATA_HOLD: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    !(rd_en_i && !empty_o) |=> $stable(rd_data_o)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!wrst_ni || !rrst_ni)
    (wbin_i - rbin_i) <= PW'(DEPTH)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge rclk_i) disable iff (!wrst_ni || !rrst_ni)
    (rd_en_i && !empty_o) |-> ((wbin_i - rbin_i) > PW'(RESERVE))); // R5
endmodule

bind rsv_async_fifo rsv_async_fifo_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESERVE(RESERVE)
) u_chk (
  .wclk_i(wclk_i), .wrst_ni(wrst_ni), .wr_en_i(wr_en_i), .full_o(full_o),
  .wbin_i(wbin), .wgray_i(wgray),
  .rclk_i(rclk_i), .rrst_ni(rrst_ni), .rd_en_i(rd_en_i), .empty_o(empty_o),
  .rbin_i(rbin), .rgray_i(rgray), .rd_data_o(rd_data_o)
);

// File: tb/sim_rsv_async_fifo.sv
module sim_rsv_async_fifo;
  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam int RSV   = 1;
  localparam int SS    = 3;
  localparam int DEPTH = 1 << AW;

  logic          wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic          wr_en = 0, rd_en = 0;
  logic [DW-1:0] wdata = '0;
  logic          full, empty;
  logic [DW-1:0] rdata;

  int  n_chk = 0, n_bad = 0;
  int  wr_acc = 0, rd_acc = 0, wr_per = 0, rd_per = 0;
  bit  run = 0, finished = 0;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  rsv_async_fifo #(.DATA_W(DW), .ADDR_W(AW), .RESERVE(RSV), .SYNC_STAGES(SS)) u0 (
    .wclk_i(wclk), .wrst_ni(wrst_n), .wr_en_i(wr_en), .wr_data_i(wdata), .full_o(full),
    .rclk_i(rclk), .rrst_ni(rrst_n), .rd_en_i(rd_en), .rd_data_o(rdata), .empty_o(empty)
  );

  function automatic logic [DW-1:0] pat(input int n);
    return DW'(n * 37 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write side: drive at negedge, full_o is stable until the next posedge
  initial begin
    int ph = 0;
    forever begin
      @(negedge wclk);
      ph++;
      if (run && wr_per != 0 && (ph % wr_per) == 0) begin
        wr_en = 1'b1;
        wdata = pat(wr_acc);
        if (!full) begin
          chk((DEPTH - (wr_acc - rd_acc)) > RSV, "R4 free>RESERVE while full low",
              DEPTH - (wr_acc - rd_acc), RSV + 1);
          wr_acc++;
        end
      end else begin
        wr_en = 1'b0;
      end
    end
  end

  // read side: data of a taken read is compared one read cycle later
  initial begin
    int ph = 0;
    bit pend = 0;
    logic [DW-1:0] last = '0;
    forever begin
      @(negedge rclk);
      ph++;
      if (run) begin
        if (pend) chk(rdata == pat(rd_acc - 1), "R3 order", rdata, pat(rd_acc - 1));
        else      chk(rdata == last, "R3 hold", rdata, last);
      end
      last = rdata;
      pend = 0;
      if (run && rd_per != 0 && (ph % rd_per) == 0) begin
        rd_en = 1'b1;
        if (!empty) begin
          chk((wr_acc - rd_acc) > RSV, "R5 occupancy>RESERVE while empty low",
              wr_acc - rd_acc, RSV + 1);
          rd_acc++;
          pend = 1;
        end
      end else begin
        rd_en = 1'b0;
      end
    end
  end

  task automatic settle();
    wr_per = 0;
    rd_per = 0;
    repeat (2) @(posedge rclk);
    repeat (2 + SS + 3) @(posedge wclk);
    repeat (SS + 3) @(posedge rclk);
    @(negedge rclk);
  endtask

  initial begin
    int occ, prev;
    logic f0, e0;
    logic [DW-1:0] d0;
    repeat (3) @(negedge wclk);
    chk(empty == 1'b1, "R6 empty in reset", empty, 1);
    chk(full == 1'b0, "R6 full in reset", full, 0);
    chk(rdata == '0, "R6 rd_data in reset", rdata, 0);
    wrst_n = 1'b1;
    rrst_n = 1'b1;
    run = 1;
    repeat (4) @(negedge rclk);
    chk(empty == 1'b1, "R6 empty after reset", empty, 1);
    chk(full == 1'b0, "R6 full after reset", full, 0);

    // reads into an empty queue
    rd_per = 1;
    repeat (20) @(negedge rclk);
    settle();
    chk(rd_acc == 0, "R2 read while empty ignored", rd_acc, 0);
    chk(rdata == '0, "R2 rd_data untouched", rdata, 0);

    for (int wp = 0; wp <= 3; wp++) begin
      for (int rp = 0; rp <= 3; rp++) begin
        prev = wr_acc - rd_acc;
        wr_per = wp;
        rd_per = rp;
        repeat (90) @(negedge wclk);
        settle();
        occ = wr_acc - rd_acc;
        chk(full == ((DEPTH - occ) <= RSV), "R7/R4 settled full", full, (DEPTH - occ) <= RSV);
        chk(empty == (occ <= RSV), "R7/R5 settled empty", empty, occ <= RSV);
        if (wp != 0 && rp == 0)
          chk(occ == DEPTH - RSV, "R1 fill stops at DEPTH-RESERVE", occ, DEPTH - RSV);
        if (wp == 0 && rp != 0)
          chk(occ == ((prev > RSV) ? RSV : prev), "R5 drain stops at RESERVE",
              occ, (prev > RSV) ? RSV : prev);
        f0 = full;
        e0 = empty;
        d0 = rdata;
        repeat (20) @(negedge rclk);
        chk(full == f0, "R8 full idle", full, f0);
        chk(empty == e0, "R8 empty idle", empty, e0);
        chk(rdata == d0, "R8 rd_data idle", rdata, d0);
      end
    end

    // writes hammered while full must not disturb content
    wr_per = 1;
    repeat (40) @(negedge wclk);
    settle();
    chk(full == 1'b1, "R1 full held under writes", full, 1);
    chk((wr_acc - rd_acc) == DEPTH - RSV, "R1 writes while full dropped",
        wr_acc - rd_acc, DEPTH - RSV);
    rd_per = 1;
    repeat (40) @(negedge rclk);
    settle();
    chk((wr_acc - rd_acc) == RSV, "R2 drain after full", wr_acc - rd_acc, RSV);

    run = 0;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule